// File: doc/BRIEF.md
# Programmable 16-bit Counter/Timer

This block is a down-counter with a 16-bit preload that software writes one byte at a time. A 3-bit control field picks one of two behaviours and the tick source. As a timer it runs without stopping: it reloads itself at terminal count and toggles a square-wave level, so it can drive a general-purpose output pin. It also raises a ready flag once per full wave period, which makes it a periodic interrupt source. As a counter it is started and halted by single-cycle command strobes. It raises the ready flag when the count reaches zero, then wraps and keeps counting until it is halted.

Tick sources arrive as single-cycle enables in the block's clock domain: an external-pin tick, the crystal tick, and the crystal divided by sixteen. Address decoding and interrupt masking stay outside the block. The block exposes the live count so that it can be read back.

Top module: `counter_timer16`

## Requirements
- R1: While `rst_n` is low, `count` is 0000h, `sq_out` is 1, `ready` is 0 and counter mode is halted. The byte preload registers are cleared.
- R2: `preload_we[1]` writes `wr_data` into preload bits [15:8] and `preload_we[0]` writes it into bits [7:0]. A preload write never changes `count` directly. It is used only by a later start or reload.
- R3: `mode_sel[2]` = 1 selects timer mode and 0 selects counter mode. `mode_sel[1:0]` selects the tick source: 00 external tick, 01 crystal tick, 10 crystal/16 tick, 11 no source, in which case no tick ever reaches the counter.
- R4: In timer mode, a tick with `count` above 1 decrements it. A tick with `count` of 0 or 1 reloads the preload and inverts `sq_out`. Each half period of `sq_out` therefore lasts preload ticks, and a preload of 0 or 1 gives one tick.
- R5: In timer mode, `ready` is set on the tick that drives `sq_out` from 0 to 1, which is once per full wave period.
- R6: A preload written while the timer runs takes effect at the next reload. It does not shorten or lengthen the half period in progress.
- R7: A start strobe without a stop strobe loads the preload into `count` on the next clock edge, in either mode. In counter mode it also begins counting.
- R8: In counter mode, every tick while running decrements `count`. The tick that takes `count` from 1 to 0 sets `ready`. The count wraps from 0000h to FFFFh and continues.
- R9: A stop strobe clears `ready` on the next edge and wins over a ready set and over a start in the same cycle. In counter mode it also halts the count, so `count` holds its value. In timer mode the wave keeps running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 3 | Bit 2: timer/counter; bits 1:0: tick source |
| ext_tick | input | 1 | External-pin tick enable |
| xtal_tick | input | 1 | Crystal tick enable |
| xtal16_tick | input | 1 | Crystal/16 tick enable |
| preload_we | input | 2 | Byte write enables: bit 1 upper, bit 0 lower |
| wr_data | input | 8 | Preload byte data |
| start_cmd | input | 1 | Start strobe, one cycle |
| stop_cmd | input | 1 | Stop strobe, one cycle |
| count | output | 16 | Current count |
| sq_out | output | 1 | Square-wave level |
| ready | output | 1 | Ready flag for interrupt status |

## Verification
The timer is run from each tick source in turn, each with a different tick rhythm, so a wrong source mapping shows up as a count that moves at the wrong rate. It is also run with the "no source" code, where any movement of the count is an error. A preload rewritten in mid half-period separates a design that reloads at terminal count from one that copies the preload at once. The counter-mode runs cover a small preload that crosses zero and wraps, a zero preload, a preload that needs the upper byte, and a start strobe together with a stop strobe. Together these expose wrong ready timing, wrong wrap behaviour, wrong byte lanes and wrong command priority.

// File: rtl/ct_pkg.sv
package ct_pkg;
  // Tick source codes carried in the low bits of the mode field
  typedef enum logic [1:0] {
    SRC_EXT    = 2'b00,
    SRC_XTAL   = 2'b01,
    SRC_XTAL16 = 2'b10,
    SRC_OFF    = 2'b11
  } ct_src_e;

  localparam int MODE_W      = 3;
  localparam int MODE_TMR_B  = 2;
endpackage

// File: rtl/ct_tick_sel.sv
module ct_tick_sel
  import ct_pkg::*;
(
  input  logic [1:0] src_sel,
  input  logic       ext_tick,
  input  logic       xtal_tick,
  input  logic       xtal16_tick,
  output logic       tick
);
  ct_src_e src;

  always_comb begin
    src = ct_src_e'(src_sel);
    unique case (src)
      SRC_EXT:    tick = ext_tick;
      SRC_XTAL:   tick = xtal_tick;
      SRC_XTAL16: tick = xtal16_tick;
      default:    tick = 1'b0;
    endcase
  end
endmodule

// File: rtl/ct_preload.sv
module ct_preload #(
  parameter int CNT_W  = 16,
  parameter int BYTE_W = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [CNT_W/BYTE_W-1:0]   byte_we,
  input  logic [BYTE_W-1:0]         wr_data,
  output logic [CNT_W-1:0]          preload
);
  localparam int NB = CNT_W / BYTE_W;

  logic [BYTE_W-1:0] byte_q [NB];

  for (genvar b = 0; b < NB; b++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        byte_q[b] <= '0;
      end else if (byte_we[b]) begin
        byte_q[b] <= wr_data;
      end
    end
    assign preload[b*BYTE_W +: BYTE_W] = byte_q[b];
  end
endmodule

// File: rtl/ct_core.sv
module ct_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             timer_mode,
  input  logic             start_cmd,
  input  logic             stop_cmd,
  input  logic [CNT_W-1:0] preload,
  output logic [CNT_W-1:0] count,
  output logic             sq_out,
  output logic             ready
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             sq_q, sq_d;
  logic             rdy_q, rdy_d;
  logic             run_q, run_d;
  logic             start_go, terminal, set_rdy;

  always_comb begin
    start_go = start_cmd & ~stop_cmd;
    terminal = (cnt_q[CNT_W-1:1] == '0);
    cnt_d    = cnt_q;
    sq_d     = sq_q;
    run_d    = run_q;
    set_rdy  = 1'b0;

    if (stop_cmd)      run_d = 1'b0;
    else if (start_go) run_d = 1'b1;

    if (timer_mode) begin
      if (start_go) begin
        cnt_d = preload;
      end else if (tick) begin
        if (terminal) begin
          cnt_d   = preload;
          sq_d    = ~sq_q;
          set_rdy = ~sq_q;
        end else begin
          cnt_d = cnt_q - ONE;
        end
      end
    end else begin
      if (start_go) begin
        cnt_d = preload;
      end else if (run_q && tick && !stop_cmd) begin
        cnt_d   = cnt_q - ONE;
        set_rdy = (cnt_q == ONE);
      end
    end

    rdy_d = stop_cmd ? 1'b0 : (rdy_q | set_rdy);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sq_q  <= 1'b1;
      rdy_q <= 1'b0;
      run_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      sq_q  <= sq_d;
      rdy_q <= rdy_d;
      run_q <= run_d;
    end
  end

  assign count  = cnt_q;
  assign sq_out = sq_q;
  assign ready  = rdy_q;
endmodule

// File: rtl/counter_timer16.sv
module counter_timer16
  import ct_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int BYTE_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [MODE_W-1:0]        mode_sel,
  input  logic                     ext_tick,
  input  logic                     xtal_tick,
  input  logic                     xtal16_tick,
  input  logic [CNT_W/BYTE_W-1:0]  preload_we,
  input  logic [BYTE_W-1:0]        wr_data,
  input  logic                     start_cmd,
  input  logic                     stop_cmd,
  output logic [CNT_W-1:0]         count,
  output logic                     sq_out,
  output logic                     ready
);
  logic             tick;
  logic [CNT_W-1:0] preload_q;

  ct_tick_sel u_tick (
    .src_sel     (mode_sel[1:0]),
    .ext_tick    (ext_tick),
    .xtal_tick   (xtal_tick),
    .xtal16_tick (xtal16_tick),
    .tick        (tick)
  );

  ct_preload #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .byte_we (preload_we),
    .wr_data (wr_data),
    .preload (preload_q)
  );

  ct_core #(.CNT_W(CNT_W)) u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .timer_mode (mode_sel[MODE_TMR_B]),
    .start_cmd  (start_cmd),
    .stop_cmd   (stop_cmd),
    .preload    (preload_q),
    .count      (count),
    .sq_out     (sq_out),
    .ready      (ready)
  );
endmodule

// File: rtl/ct_chk.sv
module ct_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       mode_sel,
  input logic             start_cmd,
  input logic             stop_cmd,
  input logic [CNT_W-1:0] count,
  input logic             sq_out,
  input logic             ready,
  input logic [CNT_W-1:0] preload
);
  // R9
  stop_clears_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_cmd |=> !ready);

  // R9
  rdy_fall_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ready) |-> $past(stop_cmd));

  // R9
  stop_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_sel[2] && stop_cmd) |=> (count == $past(count)));

  // R7
  start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_cmd && !stop_cmd) |=> (count == $past(preload)));

  // R4
  sq_timer_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sq_out) |-> $past(mode_sel[2]));

  // R5
  rdy_wave_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ready) && $past(mode_sel[2])) |-> $rose(sq_out));

  // R8
  rdy_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ready) && !$past(mode_sel[2])) |-> (count == '0));
endmodule

bind counter_timer16 ct_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mode_sel  (mode_sel),
  .start_cmd (start_cmd),
  .stop_cmd  (stop_cmd),
  .count     (count),
  .sq_out    (sq_out),
  .ready     (ready),
  .preload   (preload_q)
);

// File: tb/counter_timer16_tb.sv
`timescale 1ns/1ps
module counter_timer16_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  mode_sel = 3'b000;
  logic        ext_tick = 1'b0, xtal_tick = 1'b0, xtal16_tick = 1'b0;
  logic [1:0]  preload_we = 2'b00;
  logic [7:0]  wr_data = 8'h00;
  logic        start_cmd = 1'b0, stop_cmd = 1'b0;
  logic [15:0] count;
  logic        sq_out, ready;

  int    n_cmp = 0, n_bad = 0, cyc = 0;
  bit    done = 1'b0;
  string tag = "R1";

  // behavioural reference state
  int m_cnt, m_pre;
  bit m_sq, m_rdy, m_run;

  always #2 clk = ~clk;   // 250 MHz

  counter_timer16 u_dut (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel),
    .ext_tick(ext_tick), .xtal_tick(xtal_tick), .xtal16_tick(xtal16_tick),
    .preload_we(preload_we), .wr_data(wr_data),
    .start_cmd(start_cmd), .stop_cmd(stop_cmd),
    .count(count), .sq_out(sq_out), .ready(ready)
  );

  // Reference model: follows the requirement text
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_pre = 0; m_sq = 1; m_rdy = 0; m_run = 0;
    end else begin
      bit tk, go, rset;
      case (mode_sel[1:0])
        2'b00: tk = ext_tick;
        2'b01: tk = xtal_tick;
        2'b10: tk = xtal16_tick;
        default: tk = 1'b0;   // R3 no source
      endcase
      go = start_cmd && !stop_cmd;
      rset = 0;
      if (mode_sel[2]) begin
        if (go) m_cnt = m_pre;
        else if (tk) begin
          if (m_cnt < 2) begin
            m_cnt = m_pre;
            m_sq = !m_sq;
            if (m_sq) rset = 1;   // just went high
          end else m_cnt = m_cnt - 1;
        end
      end else begin
        if (go) m_cnt = m_pre;
        else if (m_run && tk && !stop_cmd) begin
          if (m_cnt == 1) rset = 1;
          m_cnt = (m_cnt == 0) ? 65535 : m_cnt - 1;
        end
      end
      if (stop_cmd) begin m_run = 0; m_rdy = 0; end
      else begin
        if (go) m_run = 1;
        if (rset) m_rdy = 1;
      end
      if (preload_we[1]) m_pre = (m_pre & 255) | (int'(wr_data) << 8);
      if (preload_we[0]) m_pre = (m_pre & 65280) | int'(wr_data);
    end
  end

  // Compare every clock, away from the edge
  always @(posedge clk) begin
    #1;
    if (!done) begin
      n_cmp++;
      if (count !== 16'(m_cnt) || sq_out !== m_sq || ready !== m_rdy) begin
        n_bad++;
        $display("FAIL %s cyc %0d: count=%h sq=%b rdy=%b expected count=%h sq=%b rdy=%b",
                 tag, cyc, count, sq_out, ready, 16'(m_cnt), m_sq, m_rdy);
      end
    end
  end

  // Tick enables with distinct rhythms
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      xtal_tick   = (cyc % 2 == 0);
      xtal16_tick = (cyc % 16 == 0);
      ext_tick    = (cyc % 5 == 1);
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] we, input logic [7:0] d);
    @(negedge clk); preload_we = we; wr_data = d;
    @(negedge clk); preload_we = 2'b00;
  endtask

  task automatic cmd(input bit s, input bit p);
    @(negedge clk); start_cmd = s; stop_cmd = p;
    @(negedge clk); start_cmd = 1'b0; stop_cmd = 1'b0;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #100000;
    n_bad++;
    $display("FAIL watchdog: run did not end, actual=hung expected=finished");
    finish_run();
  end

  initial begin
    step(4);
    // R1 reset state
    n_cmp++;
    if (count !== 16'h0000 || sq_out !== 1'b1 || ready !== 1'b0) begin
      n_bad++;
      $display("FAIL R1 reset: count=%h sq=%b rdy=%b expected 0000/1/0", count, sq_out, ready);
    end
    @(negedge clk); rst_n = 1'b1;
    tag = "R2"; wr(2'b10, 8'h00); wr(2'b01, 8'h05); step(3);
    tag = "R4"; mode_sel = 3'b101; step(60);
    tag = "R5"; step(20);
    tag = "R9"; cmd(1'b0, 1'b1); step(10);
    tag = "R6"; wr(2'b01, 8'h09); step(70);
    tag = "R3"; mode_sel = 3'b110; step(200);
    mode_sel = 3'b100; step(80);
    mode_sel = 3'b111; step(30);
    tag = "R7"; mode_sel = 3'b001; wr(2'b01, 8'h03); cmd(1'b1, 1'b0); step(6);
    tag = "R8"; step(20);
    tag = "R9"; cmd(1'b0, 1'b1); step(10);
    cmd(1'b1, 1'b1); step(6);
    tag = "R8"; wr(2'b01, 8'h00); cmd(1'b1, 1'b0); step(12);
    tag = "R2"; wr(2'b10, 8'h01); cmd(1'b1, 1'b0); step(20);
    tag = "R7"; mode_sel = 3'b101; cmd(1'b1, 1'b0); step(12);
    finish_run();
  end
endmodule